// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside an 8-bit processor core and owns the path from an interrupt request to the first instruction of its handler. The core pulses a boundary strobe between instructions. At that strobe the sequencer looks at the pending non-maskable request, the level interrupt lines and a latched one-shot interrupt request. It picks at most one of them, and only if the core is not jammed. For the maskable request it uses the interrupt-disable flag as it stood before the previous instruction ran, not the live flag.

Once a request is accepted the sequencer runs a fixed seven-cycle entry. There are two idle cycles, then three stack writes (return address high byte, return address low byte, status), then two vector reads. At the end it presents the new program counter, stack pointer and status. After reset it fetches the start address through the same two vector-read states and sets the status to "interrupt disable only". The core's own instruction execution is outside this block. The core takes the results when the done strobe fires.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset is released, busy_o is high for exactly 2 cycles while bytes are read from 0xFFFC (low byte) and 0xFFFD (high byte). Then pc_o equals that vector, stat_o is 0x04, sp_o is 0x00 and jammed_o is 0.
- R2: An accepted entry holds busy_o high for 7 cycles and pulses done_o for one cycle after busy_o falls. It makes exactly three writes at address {0x01, S}: the return address high byte at S, the low byte at S-1, and the status at S-2. Each write uses S modulo 256, and sp_o ends at S-3.
- R3: A maskable entry reads the vector from 0xFFFE/0xFFFF. The resulting stat_o has bit 2 (interrupt disable) set and bit 4 (break) cleared.
- R4: A non-maskable entry reads the vector from 0xFFFA/0xFFFB. The resulting stat_o equals stat_i with bit 4 cleared and bit 2 left as it was.
- R5: When a non-maskable request is pending at a boundary, it is serviced even if a maskable request is also present.
- R6: A maskable request is accepted only when irq_mask_prev_i is 0. The live bit 2 of stat_i does not block it.
- R7: A pulse on jam_i sets jammed_o, which stays set until reset. While it is set, no entry of either kind starts.
- R8: At any idle boundary where a request is pending, the pending non-maskable and one-shot requests are cleared, whether or not an entry starts. The level lines are not cleared, so they are taken again at a later boundary.
- R9: boundary_i is ignored while busy_o is high. A request that arrives during an entry stays pending for the next boundary.
- R10: Any single bit of irq_lvl_i raises a maskable request.
- R11: The pushed status byte is the captured status with bit 4 cleared and bit 5 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| irq_lvl_i | input | NSRC | Level interrupt lines, one per source |
| irq_pulse_i | input | 1 | One-shot interrupt request, latched |
| nmi_req_i | input | 1 | Non-maskable request pulse, latched |
| jam_i | input | 1 | Sets the jammed state |
| irq_mask_prev_i | input | 1 | Interrupt-disable flag sampled before the previous instruction |
| stat_i | input | 8 | Current status byte |
| pc_i | input | 16 | Return address to push |
| sp_i | input | 8 | Current stack pointer |
| mem_rdata_i | input | 8 | Read data, valid in the cycle mem_re_o is high |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| pc_o | output | 16 | New program counter |
| sp_o | output | 8 | New stack pointer |
| stat_o | output | 8 | New status byte |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle strobe after a sequence ends |
| jammed_o | output | 1 | Jammed state |

## Verification
The bench uses four level sources (NSRC = 4) and the stack page 0x01. With four sources it drives the lowest, highest and middle lines one at a time to show that each alone raises a request. With stack pointers of 0x02 and 0x01 it forces the pushes to wrap from 0x0100 to 0x01FF and sp_o to cross zero. Requests are issued during a running entry, while the core is jammed, and while masked. These cases expose the consumption and carry-over rules at the boundary.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DUMMY_A,
    ST_DUMMY_B,
    ST_PUSH_PCH,
    ST_PUSH_PCL,
    ST_PUSH_STAT,
    ST_VEC_LO,
    ST_VEC_HI
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_IRQ,
    SRC_NMI,
    SRC_RST
  } entry_src_e;

  localparam logic [7:0]  MASK_I = 8'h04;
  localparam logic [7:0]  MASK_B = 8'h10;
  localparam logic [7:0]  MASK_U = 8'h20;

  localparam logic [15:0] VEC_NMI = 16'hFFFA;
  localparam logic [15:0] VEC_RST = 16'hFFFC;
  localparam logic [15:0] VEC_IRQ = 16'hFFFE;

  localparam int ENTRY_CYCLES = 7;

endpackage

// File: rtl/irq_req_track.sv
module irq_req_track #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boundary_i,
  input  logic            nmi_req_i,
  input  logic            irq_pulse_i,
  input  logic [NSRC-1:0] irq_lvl_i,
  input  logic            jam_i,
  input  logic            irq_mask_prev_i,
  output logic            take_nmi_o,
  output logic            take_irq_o,
  output logic            jammed_o
);

  logic nmi_pend_q, nmi_pend_d, nmi_en;
  logic osh_q, osh_d, osh_en;
  logic jam_q, jam_d, jam_en;
  logic irq_any, consume;

  always_comb begin
    irq_any    = (|irq_lvl_i) | osh_q;
    consume    = boundary_i & (nmi_pend_q | irq_any);
    nmi_pend_d = nmi_req_i | (nmi_pend_q & ~consume);
    nmi_en     = nmi_req_i | consume;
    osh_d      = irq_pulse_i | (osh_q & ~consume);
    osh_en     = irq_pulse_i | consume;
    jam_d      = 1'b1;
    jam_en     = jam_i;
    take_nmi_o = boundary_i & nmi_pend_q & ~jam_q;
    take_irq_o = boundary_i & ~nmi_pend_q & irq_any & ~irq_mask_prev_i & ~jam_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pend_q <= 1'b0;
      osh_q      <= 1'b0;
      jam_q      <= 1'b0;
    end else begin
      if (nmi_en) nmi_pend_q <= nmi_pend_d;
      if (osh_en) osh_q      <= osh_d;
      if (jam_en) jam_q      <= jam_d;
    end
  end

  assign jammed_o = jam_q;

  assert_single_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_nmi_o, take_irq_o}));

  assert_jam_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    jam_q |=> jam_q);

  assert_jam_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    jam_q |-> !(take_nmi_o || take_irq_o));

  assert_nmi_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && nmi_pend_q && !nmi_req_i) |=> !nmi_pend_q);

  assert_osh_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && osh_q && !irq_pulse_i) |=> !osh_q);

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take_nmi_i,
  input  logic        take_irq_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  sp_i,
  input  logic [7:0]  stat_i,
  input  logic [7:0]  mem_rdata_i,
  output logic [15:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  output logic        mem_we_o,
  output logic        mem_re_o,
  output logic [15:0] pc_o,
  output logic [7:0]  sp_o,
  output logic [7:0]  stat_o,
  output logic        busy_o,
  output logic        done_o
);

  localparam int RUN_W = $clog2(ENTRY_CYCLES + 1) + 1;

  seq_state_e state_q, state_d;
  entry_src_e src_q, src_d;
  logic [15:0] pc_q, pc_d;
  logic [7:0]  sp_q, sp_d, stat_q, stat_d;
  logic        done_q, done_d;
  logic        src_en, pc_en, sp_en, stat_en;
  logic [15:0] vec_base;

  always_comb begin
    case (src_q)
      SRC_NMI: vec_base = VEC_NMI;
      SRC_IRQ: vec_base = VEC_IRQ;
      default: vec_base = VEC_RST;
    endcase
  end

  always_comb begin
    state_d     = state_q;
    src_d       = src_q;
    pc_d        = pc_q;
    sp_d        = sp_q;
    stat_d      = stat_q;
    done_d      = 1'b0;
    src_en      = 1'b0;
    pc_en       = 1'b0;
    sp_en       = 1'b0;
    stat_en     = 1'b0;
    mem_addr_o  = {STACK_PAGE, sp_q};
    mem_wdata_o = 8'h00;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (take_nmi_i || take_irq_i) begin
          state_d = ST_DUMMY_A;
          src_d   = take_nmi_i ? SRC_NMI : SRC_IRQ;
          pc_d    = pc_i;
          sp_d    = sp_i;
          stat_d  = stat_i & ~MASK_B;
          src_en  = 1'b1;
          pc_en   = 1'b1;
          sp_en   = 1'b1;
          stat_en = 1'b1;
        end
      end
      ST_DUMMY_A: state_d = ST_DUMMY_B;
      ST_DUMMY_B: state_d = ST_PUSH_PCH;
      ST_PUSH_PCH: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = pc_q[15:8];
        sp_d        = sp_q - 8'd1;
        sp_en       = 1'b1;
        state_d     = ST_PUSH_PCL;
      end
      ST_PUSH_PCL: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = pc_q[7:0];
        sp_d        = sp_q - 8'd1;
        sp_en       = 1'b1;
        state_d     = ST_PUSH_STAT;
      end
      ST_PUSH_STAT: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = stat_q | MASK_U;
        sp_d        = sp_q - 8'd1;
        sp_en       = 1'b1;
        if (src_q == SRC_IRQ) begin
          stat_d  = stat_q | MASK_I;
          stat_en = 1'b1;
        end
        state_d = ST_VEC_LO;
      end
      ST_VEC_LO: begin
        mem_re_o   = 1'b1;
        mem_addr_o = vec_base;
        pc_d       = {pc_q[15:8], mem_rdata_i};
        pc_en      = 1'b1;
        state_d    = ST_VEC_HI;
      end
      ST_VEC_HI: begin
        mem_re_o   = 1'b1;
        mem_addr_o = vec_base | 16'h0001;
        pc_d       = {mem_rdata_i, pc_q[7:0]};
        pc_en      = 1'b1;
        done_d     = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_VEC_LO;
      src_q   <= SRC_RST;
      pc_q    <= 16'h0000;
      sp_q    <= 8'h00;
      stat_q  <= MASK_I;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (src_en)  src_q  <= src_d;
      if (pc_en)   pc_q   <= pc_d;
      if (sp_en)   sp_q   <= sp_d;
      if (stat_en) stat_q <= stat_d;
    end
  end

  assign pc_o   = pc_q;
  assign sp_o   = sp_q;
  assign stat_o = stat_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assert_entry_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (int'(run_q) < ENTRY_CYCLES));

  assert_we_stack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o[15:8] == STACK_PAGE));

  assert_rw_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_irq_sets_i_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VEC_HI && src_q == SRC_IRQ) |-> stat_q[2]);

  assert_push_u_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH_STAT) |-> (mem_wdata_o[5] && !mem_wdata_o[4]));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int         NSRC       = 4,
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boundary_i,
  input  logic [NSRC-1:0] irq_lvl_i,
  input  logic            irq_pulse_i,
  input  logic            nmi_req_i,
  input  logic            jam_i,
  input  logic            irq_mask_prev_i,
  input  logic [7:0]      stat_i,
  input  logic [15:0]     pc_i,
  input  logic [7:0]      sp_i,
  input  logic [7:0]      mem_rdata_i,
  output logic [15:0]     mem_addr_o,
  output logic [7:0]      mem_wdata_o,
  output logic            mem_we_o,
  output logic            mem_re_o,
  output logic [15:0]     pc_o,
  output logic [7:0]      sp_o,
  output logic [7:0]      stat_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            jammed_o
);

  logic bnd_ok, take_nmi, take_irq;

  assign bnd_ok = boundary_i & ~busy_o;

  irq_req_track #(.NSRC(NSRC)) u_track (
    .clk             (clk),
    .rst_n           (rst_n),
    .boundary_i      (bnd_ok),
    .nmi_req_i       (nmi_req_i),
    .irq_pulse_i     (irq_pulse_i),
    .irq_lvl_i       (irq_lvl_i),
    .jam_i           (jam_i),
    .irq_mask_prev_i (irq_mask_prev_i),
    .take_nmi_o      (take_nmi),
    .take_irq_o      (take_irq),
    .jammed_o        (jammed_o)
  );

  irq_entry_fsm #(.STACK_PAGE(STACK_PAGE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_nmi_i  (take_nmi),
    .take_irq_i  (take_irq),
    .pc_i        (pc_i),
    .sp_i        (sp_i),
    .stat_i      (stat_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .pc_o        (pc_o),
    .sp_o        (sp_o),
    .stat_o      (stat_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  assert_start_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(boundary_i));

  assert_vec_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |-> (mem_addr_o[15:3] == 13'h1FFF));

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;

  localparam int NSRC = 4;

  typedef struct packed {
    logic [3:0]  lvl;
    logic        osh;
    logic        nmi;
    logic        mprev;
    logic [7:0]  st;
    logic [15:0] pc;
    logic [7:0]  sp;
    logic [1:0]  kind;
  } vec_t;

  localparam vec_t TBL [0:9] = '{
    '{4'b0001, 1'b0, 1'b0, 1'b0, 8'hC3, 16'h8042, 8'hFD, 2'd1},
    '{4'b1000, 1'b0, 1'b0, 1'b0, 8'h11, 16'h00FF, 8'h02, 2'd1},
    '{4'b0000, 1'b0, 1'b1, 1'b0, 8'h04, 16'hC000, 8'hF0, 2'd2},
    '{4'b0010, 1'b0, 1'b1, 1'b0, 8'h80, 16'h1357, 8'hE0, 2'd2},
    '{4'b0100, 1'b0, 1'b0, 1'b1, 8'h00, 16'h2222, 8'hD0, 2'd0},
    '{4'b0001, 1'b0, 1'b0, 1'b0, 8'h04, 16'h3333, 8'hC0, 2'd1},
    '{4'b0000, 1'b1, 1'b0, 1'b0, 8'h40, 16'h4444, 8'hB0, 2'd1},
    '{4'b0000, 1'b1, 1'b0, 1'b1, 8'h00, 16'h5555, 8'hA0, 2'd0},
    '{4'b0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h6666, 8'h90, 2'd0},
    '{4'b0000, 1'b0, 1'b1, 1'b1, 8'hFF, 16'h7777, 8'h01, 2'd2}
  };

  localparam string TAGS [0:9] = '{
    "R3 R10 line0", "R10 R11 line3 wrap", "R4 nmi", "R5 priority",
    "R6 masked prev", "R6 live flag", "R3 one-shot", "R8 masked one-shot",
    "R8 one-shot cleared", "R4 R2 nmi wrap"
  };

  logic clk, rst_n, boundary, irq_pulse, nmi_req, jam, mask_prev;
  logic [NSRC-1:0] irq_lvl;
  logic [7:0] stat_in, sp_in, mem_rdata, mem_wdata, sp_o, stat_o;
  logic [15:0] pc_in, mem_addr, pc_o;
  logic mem_we, mem_re, busy, done, jammed;

  int checks = 0;
  int errors = 0;
  int wn = 0, bc = 0, rc = 0, dc = 0;
  int wa [0:255];
  int wd [0:255];
  logic [15:0] exp_pc;
  logic [7:0]  exp_sp, exp_st;

  irq_entry_seq #(.NSRC(NSRC), .STACK_PAGE(8'h01)) u_irq_entry_seq (
    .clk (clk), .rst_n (rst_n), .boundary_i (boundary), .irq_lvl_i (irq_lvl),
    .irq_pulse_i (irq_pulse), .nmi_req_i (nmi_req), .jam_i (jam),
    .irq_mask_prev_i (mask_prev), .stat_i (stat_in), .pc_i (pc_in), .sp_i (sp_in),
    .mem_rdata_i (mem_rdata), .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata),
    .mem_we_o (mem_we), .mem_re_o (mem_re), .pc_o (pc_o), .sp_o (sp_o),
    .stat_o (stat_o), .busy_o (busy), .done_o (done), .jammed_o (jammed)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    case (a)
      16'hFFFA: return 8'h11;
      16'hFFFB: return 8'h22;
      16'hFFFC: return 8'h34;
      16'hFFFD: return 8'h12;
      16'hFFFE: return 8'hCD;
      16'hFFFF: return 8'hAB;
      default:  return 8'hEE;
    endcase
  endfunction

  always_comb mem_rdata = rom_byte(mem_addr);

  always @(negedge clk) begin
    if (mem_we) begin
      wa[wn % 256] = int'(mem_addr);
      wd[wn % 256] = int'(mem_wdata);
      wn = wn + 1;
    end
    if (mem_re) rc = rc + 1;
    if (busy)   bc = bc + 1;
    if (done)   dc = dc + 1;
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_case(input logic [3:0] lvl, input logic osh, input logic nmi,
                          input logic mprev, input logic [7:0] st, input logic [15:0] pc,
                          input logic [7:0] sp, input logic [1:0] kind, input string tag);
    int w0, b0, d0;
    logic [7:0] s1, s2;
    tick;
    w0 = wn; b0 = bc; d0 = dc;
    irq_lvl = lvl; mask_prev = mprev; stat_in = st; pc_in = pc; sp_in = sp;
    nmi_req = nmi; irq_pulse = osh;
    tick;
    nmi_req = 1'b0; irq_pulse = 1'b0; boundary = 1'b1;
    tick;
    boundary = 1'b0;
    repeat (9) tick;
    if (kind != 2'd0) begin
      s1 = sp - 8'd1;
      s2 = sp - 8'd2;
      exp_pc = (kind == 2'd2) ? 16'h2211 : 16'hABCD;
      exp_sp = sp - 8'd3;
      exp_st = (st & ~8'h10) | ((kind == 2'd1) ? 8'h04 : 8'h00);
      chk({tag, " R2 write count"}, wn - w0, 3);
      chk({tag, " R2 busy cycles"}, bc - b0, 7);
      chk({tag, " R2 done pulses"}, dc - d0, 1);
      chk({tag, " R2 pch addr"}, wa[w0 % 256], {16'h0, 8'h01, sp});
      chk({tag, " R2 pch data"}, wd[w0 % 256], {24'h0, pc[15:8]});
      chk({tag, " R2 pcl addr"}, wa[(w0 + 1) % 256], {16'h0, 8'h01, s1});
      chk({tag, " R2 pcl data"}, wd[(w0 + 1) % 256], {24'h0, pc[7:0]});
      chk({tag, " R11 stat addr"}, wa[(w0 + 2) % 256], {16'h0, 8'h01, s2});
      chk({tag, " R11 stat data"}, wd[(w0 + 2) % 256], {24'h0, (st & ~8'h10) | 8'h20});
    end else begin
      chk({tag, " no writes"}, wn - w0, 0);
      chk({tag, " no busy"}, bc - b0, 0);
    end
    chk({tag, " pc_o"}, {16'h0, pc_o}, {16'h0, exp_pc});
    chk({tag, " sp_o"}, {24'h0, sp_o}, {24'h0, exp_sp});
    chk({tag, " stat_o"}, {24'h0, stat_o}, {24'h0, exp_st});
    irq_lvl = '0;
  endtask

  task automatic do_reset(input string tag);
    int b0, r0;
    rst_n = 1'b0;
    repeat (3) tick;
    rst_n = 1'b1;
    b0 = bc; r0 = rc;
    repeat (4) tick;
    exp_pc = 16'h1234; exp_sp = 8'h00; exp_st = 8'h04;
    chk({tag, " R1 busy cycles"}, bc - b0, 2);
    chk({tag, " R1 reads"}, rc - r0, 2);
    chk({tag, " R1 pc_o"}, {16'h0, pc_o}, 32'h1234);
    chk({tag, " R1 stat_o"}, {24'h0, stat_o}, 32'h04);
    chk({tag, " R1 sp_o"}, {24'h0, sp_o}, 32'h00);
    chk({tag, " R1 R7 jammed_o"}, {31'h0, jammed}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w0, b0;
    rst_n = 1'b0; boundary = 1'b0; irq_pulse = 1'b0; nmi_req = 1'b0; jam = 1'b0;
    mask_prev = 1'b0; irq_lvl = '0; stat_in = 8'h00; pc_in = 16'h0000; sp_in = 8'h00;
    do_reset("power-up");

    for (int i = 0; i < 10; i++)
      run_case(TBL[i].lvl, TBL[i].osh, TBL[i].nmi, TBL[i].mprev, TBL[i].st,
               TBL[i].pc, TBL[i].sp, TBL[i].kind, TAGS[i]);

    run_case(4'b0001, 1'b1, 1'b0, 1'b1, 8'h00, 16'h0A0A, 8'h80, 2'd0, "R8 level masked");
    run_case(4'b0001, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0B0B, 8'h80, 2'd1, "R8 level retaken");

    tick;
    w0 = wn; b0 = bc;
    nmi_req = 1'b1;
    tick;
    nmi_req = 1'b0; boundary = 1'b1; pc_in = 16'h0C0C; sp_in = 8'h70; stat_in = 8'h00;
    tick;
    boundary = 1'b0;
    tick;
    nmi_req = 1'b1;
    tick;
    nmi_req = 1'b0; boundary = 1'b1;
    tick;
    boundary = 1'b0;
    repeat (8) tick;
    chk("R9 single entry busy", bc - b0, 7);
    chk("R9 single entry writes", wn - w0, 3);
    chk("R9 first pc_o", {16'h0, pc_o}, 32'h2211);
    run_case(4'b0000, 1'b0, 1'b0, 1'b0, 8'h01, 16'h0D0D, 8'h60, 2'd2, "R9 held request");

    tick;
    jam = 1'b1;
    tick;
    jam = 1'b0;
    tick;
    chk("R7 jammed_o set", {31'h0, jammed}, 32'h1);
    run_case(4'b0000, 1'b0, 1'b1, 1'b0, 8'h00, 16'h0E0E, 8'h50, 2'd0, "R7 nmi blocked");
    run_case(4'b0100, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0F0F, 8'h50, 2'd0, "R7 irq blocked");
    chk("R7 jammed_o held", {31'h0, jammed}, 32'h1);
    run_case(4'b0000, 1'b0, 1'b1, 1'b0, 8'h00, 16'h1010, 8'h50, 2'd0, "R7 nmi still blocked");

    do_reset("R7 re-reset");
    run_case(4'b0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h1111, 8'h40, 2'd0, "R8 consumed while jammed");
    run_case(4'b0010, 1'b0, 1'b0, 1'b0, 8'h08, 16'h1212, 8'h40, 2'd1, "R7 R10 unjammed line1");

    finish_run();
  end

endmodule